// File: doc/BRIEF.md
# Trigger Header Word Serializer

This block takes the payload that comes with each accepted trigger (an 8-bit event number, an 8-bit bunch-crossing number and a 7-bit readout-type field) and stores it. It then plays the payload out to downstream readout modules as three 8-bit words on a shared parallel bus, one word per clock. A 2-bit select code sits beside the data and tells each receiver which word is on the bus. The stored values also appear as two 16-bit read-only register images, which a host bus decoder outside this block can read.

The sequencing uses four named states. `S_IDLE` drives select code 11 (bus invalid). `S_TYPE` drives the readout-type word with code 00. `S_EVT` drives the event number with code 01. `S_BX` drives the bunch-crossing number with code 10. There are four transitions. `S_IDLE -> S_TYPE` happens on a clock edge where `trig_accept` is high; that same edge captures the payload. `S_TYPE -> S_EVT` and `S_EVT -> S_BX` are unconditional. `S_BX -> S_IDLE` is also unconditional. Outside `S_IDLE`, `trig_accept` is ignored. The burst-accept flag `hdr_accept` is high in the three sending states.

Top module: `trig_hdr_serializer`

## Requirements
- R1: After reset, `hdr_sel` is 11, `hdr_data` is 0, `hdr_accept` is 0, and both register images read 0.
- R2: When `trig_accept` is high at an edge while the block is idle, the next cycle shows select code 00, `hdr_accept` high, and the readout type on `hdr_data` as `{1'b0, trig_type}`.
- R3: The words follow one another on consecutive cycles in a fixed order: code 00 with the readout type, then code 01 with the event number, then code 10 with the bunch-crossing number.
- R4: In the cycle after the code-10 word, `hdr_sel` goes back to 11, and it stays 11 with `hdr_data` 0 and `hdr_accept` 0 until the next accepted trigger.
- R5: A `trig_accept` seen at any edge during a burst, including the edge that ends the code-10 word, changes neither the captured payload nor the sequence. The next accept taken while idle starts again at code 00.
- R6: The number image `num_reg` holds the event number in bits 7:0 and the bunch-crossing number in bits 15:8. Both are refreshed at the edge that accepts a trigger.
- R7: The control image `ctrl_reg` holds `trig_type` in bits 11:5: system bits [1:0] in 6:5, ambiguity bits [3:2] in 8:7, and user bits [6:4] in 11:9. It holds the abort flag in bit 12 and the accept flag in bit 13. Bits 4:0, 15 and 14 read 0.
- R8: Bit 13 is set by the first accepted trigger and stays set until reset. Bit 12 is set at any edge where `trig_abort` is high. It stays set until an accepted trigger with `trig_abort` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous overall reset |
| trig_accept | input | 1 | Trigger accept strobe, payload valid with it |
| trig_abort | input | 1 | Abort of the last accepted trigger |
| trig_evt | input | 8 | Event number |
| trig_bx | input | 8 | Bunch-crossing number |
| trig_type | input | 7 | Readout type (system, ambiguity, user bits) |
| hdr_data | output | 8 | Header word on the shared bus |
| hdr_sel | output | 2 | Word-select code, 11 = invalid |
| hdr_accept | output | 1 | High while a header word is on the bus |
| num_reg | output | 16 | Host image: bunch-crossing and event numbers |
| ctrl_reg | output | 16 | Host image: readout type, abort and accept flags |

## Verification
The assertions take for granted that `trig_accept` and `trig_abort` are synchronous to `clk` and settle before each edge. They also assume the payload is valid in the cycle in which the accept is seen. The bench drives every input on the falling edge and holds the payload steady while `trig_accept` is high. It also fires accepts inside a burst on purpose, with a different payload, so that the ignore rule is exercised.

// File: rtl/trig_hdr_pkg.sv
package trig_hdr_pkg;
    parameter int WORD_W = 8;
    parameter int TYPE_W = 7;
    parameter int SEL_W  = 2;
    parameter int REG_W  = 16;

    localparam int TYPE_LSB = 5;
    localparam int ABT_BIT  = TYPE_LSB + TYPE_W;
    localparam int ACC_BIT  = ABT_BIT + 1;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TYPE,
        S_EVT,
        S_BX
    } hdr_state_t;

    localparam logic [SEL_W-1:0] SEL_TYPE = 2'b00;
    localparam logic [SEL_W-1:0] SEL_EVT  = 2'b01;
    localparam logic [SEL_W-1:0] SEL_BX   = 2'b10;
    localparam logic [SEL_W-1:0] SEL_NONE = 2'b11;
endpackage

// File: rtl/trig_hdr_fsm.sv
module trig_hdr_fsm
    import trig_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    output logic             capture,
    output logic [SEL_W-1:0] sel,
    output logic             busy
);
    hdr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_TYPE;
            S_TYPE: state_d = S_EVT;
            S_EVT:  state_d = S_BX;
            S_BX:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        sel     = SEL_NONE;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                capture = accept;
                busy    = 1'b0;
            end
            S_TYPE: sel = SEL_TYPE;
            S_EVT:  sel = SEL_EVT;
            S_BX:   sel = SEL_BX;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_hdr_capture.sv
module trig_hdr_capture
    import trig_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              abort,
    input  logic [WORD_W-1:0] evt,
    input  logic [WORD_W-1:0] bx,
    input  logic [TYPE_W-1:0] rtype,
    output logic [WORD_W-1:0] evt_q,
    output logic [WORD_W-1:0] bx_q,
    output logic [TYPE_W-1:0] rtype_q,
    output logic              abt_q,
    output logic              acc_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q   <= '0;
            bx_q    <= '0;
            rtype_q <= '0;
            abt_q   <= 1'b0;
            acc_q   <= 1'b0;
        end else begin
            if (capture) begin
                evt_q   <= evt;
                bx_q    <= bx;
                rtype_q <= rtype;
                acc_q   <= 1'b1;
            end
            abt_q <= abort | (abt_q & ~capture);
        end
    end
endmodule

// File: rtl/trig_hdr_mux.sv
module trig_hdr_mux
    import trig_hdr_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] evt_q,
    input  logic [WORD_W-1:0] bx_q,
    input  logic [TYPE_W-1:0] rtype_q,
    output logic [WORD_W-1:0] data
);
    localparam int PAD_W = WORD_W - TYPE_W;

    always_comb begin
        unique case (sel)
            SEL_TYPE: data = {{PAD_W{1'b0}}, rtype_q};
            SEL_EVT:  data = evt_q;
            SEL_BX:   data = bx_q;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/trig_hdr_serializer.sv
module trig_hdr_serializer
    import trig_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_accept,
    input  logic              trig_abort,
    input  logic [WORD_W-1:0] trig_evt,
    input  logic [WORD_W-1:0] trig_bx,
    input  logic [TYPE_W-1:0] trig_type,
    output logic [WORD_W-1:0] hdr_data,
    output logic [SEL_W-1:0]  hdr_sel,
    output logic              hdr_accept,
    output logic [REG_W-1:0]  num_reg,
    output logic [REG_W-1:0]  ctrl_reg
);
    localparam int TOP_PAD = REG_W - ACC_BIT - 1;

    logic              capture;
    logic [WORD_W-1:0] evt_q, bx_q;
    logic [TYPE_W-1:0] rtype_q;
    logic              abt_q, acc_q;

    trig_hdr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (trig_accept),
        .capture (capture),
        .sel     (hdr_sel),
        .busy    (hdr_accept)
    );

    trig_hdr_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .abort   (trig_abort),
        .evt     (trig_evt),
        .bx      (trig_bx),
        .rtype   (trig_type),
        .evt_q   (evt_q),
        .bx_q    (bx_q),
        .rtype_q (rtype_q),
        .abt_q   (abt_q),
        .acc_q   (acc_q)
    );

    trig_hdr_mux u_mux (
        .sel     (hdr_sel),
        .evt_q   (evt_q),
        .bx_q    (bx_q),
        .rtype_q (rtype_q),
        .data    (hdr_data)
    );

    assign num_reg  = {bx_q, evt_q};
    assign ctrl_reg = {{TOP_PAD{1'b0}}, acc_q, abt_q, rtype_q, {TYPE_LSB{1'b0}}};
endmodule

// File: rtl/trig_hdr_serializer_chk.sv
module trig_hdr_serializer_chk
    import trig_hdr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trig_accept,
    input logic              trig_abort,
    input logic [SEL_W-1:0]  hdr_sel,
    input logic [WORD_W-1:0] hdr_data,
    input logic              hdr_accept,
    input logic [REG_W-1:0]  num_reg,
    input logic [REG_W-1:0]  ctrl_reg
);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_accept && hdr_sel == SEL_NONE) |=> (hdr_sel == SEL_TYPE && hdr_accept));
    // R3
    evt_after_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_sel == SEL_TYPE) |=> (hdr_sel == SEL_EVT));
    // R3
    bx_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_sel == SEL_EVT) |=> (hdr_sel == SEL_BX));
    // R4
    idle_after_bx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_sel == SEL_BX) |=> (hdr_sel == SEL_NONE));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_accept) |-> (hdr_sel == SEL_NONE && hdr_data == '0));
    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_sel != SEL_NONE) |=> $stable(num_reg));
    // R8
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_abort |=> ctrl_reg[ABT_BIT]);
    // R8
    acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg[ACC_BIT] |=> ctrl_reg[ACC_BIT]);
endmodule

bind trig_hdr_serializer trig_hdr_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_accept (trig_accept),
    .trig_abort  (trig_abort),
    .hdr_sel     (hdr_sel),
    .hdr_data    (hdr_data),
    .hdr_accept  (hdr_accept),
    .num_reg     (num_reg),
    .ctrl_reg    (ctrl_reg)
);

// File: tb/trig_hdr_serializer_bench.sv
module trig_hdr_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_accept = 1'b0;
    logic        trig_abort = 1'b0;
    logic [7:0]  trig_evt = '0;
    logic [7:0]  trig_bx = '0;
    logic [6:0]  trig_type = '0;
    logic [7:0]  hdr_data;
    logic [1:0]  hdr_sel;
    logic        hdr_accept;
    logic [15:0] num_reg;
    logic [15:0] ctrl_reg;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    trig_hdr_serializer u_trig_hdr_serializer (
        .clk(clk), .rst_n(rst_n), .trig_accept(trig_accept), .trig_abort(trig_abort),
        .trig_evt(trig_evt), .trig_bx(trig_bx), .trig_type(trig_type),
        .hdr_data(hdr_data), .hdr_sel(hdr_sel), .hdr_accept(hdr_accept),
        .num_reg(num_reg), .ctrl_reg(ctrl_reg)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl_img(input logic acc, input logic abt, input logic [6:0] t);
        return {2'b00, acc, abt, t, 5'b00000};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 sel", {14'd0, hdr_sel}, 16'h0003);
        chk("R1 data", {8'd0, hdr_data}, 16'h0000);
        chk("R1 accept", {15'd0, hdr_accept}, 16'h0000);
        chk("R1 num", num_reg, 16'h0000);
        chk("R1 ctrl", ctrl_reg, 16'h0000);
        rst_n = 1'b1;
        step();
    endtask

    // R2 R3 R4 R6 R7: one burst, with an optional abort in the accept cycle
    task automatic t_burst(input logic [6:0] t, input logic [7:0] e, input logic [7:0] b, input logic abt);
        trig_type = t; trig_evt = e; trig_bx = b; trig_accept = 1'b1; trig_abort = abt;
        step();
        trig_accept = 1'b0; trig_abort = 1'b0;
        chk("R2 sel type", {14'd0, hdr_sel}, 16'h0000);
        chk("R2 accept", {15'd0, hdr_accept}, 16'h0001);
        chk("R2 data type", {8'd0, hdr_data}, {9'd0, t});
        chk("R6 num", num_reg, {b, e});
        chk("R7 ctrl", ctrl_reg, ctrl_img(1'b1, abt, t));
        step();
        chk("R3 sel evt", {14'd0, hdr_sel}, 16'h0001);
        chk("R3 data evt", {8'd0, hdr_data}, {8'd0, e});
        step();
        chk("R3 sel bx", {14'd0, hdr_sel}, 16'h0002);
        chk("R3 data bx", {8'd0, hdr_data}, {8'd0, b});
        step();
        chk("R4 sel none", {14'd0, hdr_sel}, 16'h0003);
        chk("R4 data zero", {8'd0, hdr_data}, 16'h0000);
        chk("R4 accept low", {15'd0, hdr_accept}, 16'h0000);
        step();
        chk("R4 still idle", {14'd0, hdr_sel}, 16'h0003);
    endtask

    // R5: accepts at every edge of a burst, including the one ending word 10
    task automatic t_ignore();
        trig_type = 7'h15; trig_evt = 8'hA1; trig_bx = 8'hB2; trig_accept = 1'b1;
        step();
        trig_type = 7'h6A; trig_evt = 8'h5E; trig_bx = 8'h4D;
        chk("R5 start", {14'd0, hdr_sel}, 16'h0000);
        step();
        chk("R5 evt kept", {8'd0, hdr_data}, 16'h00A1);
        chk("R5 sel evt", {14'd0, hdr_sel}, 16'h0001);
        step();
        chk("R5 bx kept", {8'd0, hdr_data}, 16'h00B2);
        step();
        trig_accept = 1'b0;
        chk("R5 no restart", {14'd0, hdr_sel}, 16'h0003);
        chk("R5 num kept", num_reg, 16'hB2A1);
        chk("R5 ctrl kept", ctrl_reg, ctrl_img(1'b1, 1'b0, 7'h15));
        step();
        t_burst(7'h6A, 8'h5E, 8'h4D, 1'b0);
    endtask

    // R8: abort flag set while idle, kept, then cleared by next accept
    task automatic t_abort();
        trig_abort = 1'b1;
        step();
        trig_abort = 1'b0;
        chk("R8 abort set", {15'd0, ctrl_reg[12]}, 16'h0001);
        step(); step();
        chk("R8 abort held", {15'd0, ctrl_reg[12]}, 16'h0001);
        chk("R8 accept held", {15'd0, ctrl_reg[13]}, 16'h0001);
        t_burst(7'h7F, 8'hFF, 8'h00, 1'b0);
        chk("R8 abort cleared", {15'd0, ctrl_reg[12]}, 16'h0000);
    endtask

    task automatic t_random();
        for (int i = 0; i < 20; i++) begin
            logic [31:0] r;
            r = $urandom;
            t_burst(r[6:0], r[15:8], r[23:16], r[24]);
        end
    endtask

    initial begin
        step();
        t_reset();
        t_burst(7'h2B, 8'h3C, 8'hC3, 1'b0);
        t_burst(7'h00, 8'h01, 8'h80, 1'b1);
        t_ignore();
        t_abort();
        t_random();
        t_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule